// File: doc/BRIEF.md
# Shutter and T0-Sync Sequencer with Busy Merge

This block drives the shared shutter and time-stamp synchronisation strobe that go to a group of pixel readout chips, and it builds the single busy line that is returned to the trigger unit. When the host requests a resynchronisation, the block closes the shutter. After a short margin it pulses the synchronisation strobe, which makes every chip restart its time stamp from zero. It then holds the shutter closed for a programmable gap and reopens it. A one-cycle done flag marks the reopening. An optional reset pulse to the chips can be issued while the shutter is still closed and before the strobe.

Busy is a pure combinational OR of two kinds of source. The first is the almost-full flags of the local output buffers, which is how back-pressure from the host network reaches this block. The second is a software halt bit. The block runs on the 40 MHz system clock, so one cycle is 25 ns.

Top module: `sync_seq`

## Requirements
- R1: After reset the shutter output is 1 (open), and t0_sync, chip_rst and done are all 0.
- R2: A sync_req sampled high while the block is idle makes shutter go to 0 in the next cycle. Shutter then stays 0 for PRE_CYC cycles (default 2) before t0_sync rises.
- R3: t0_sync is 1 for exactly PULSE_CYC consecutive cycles (default 1), and shutter is 0 throughout those cycles.
- R4: After t0_sync falls, shutter stays 0 for G cycles and then returns to 1. G is gap_cycles if that value is at least MIN_GAP (default 65), and MIN_GAP otherwise.
- R5: gap_cycles and rst_en are sampled only in the cycle the request is accepted. Changes to them during a running sequence have no effect on that sequence.
- R6: A sync_req that arrives while a sequence is running is ignored. The running sequence keeps its length, and no new sequence starts once it ends.
- R7: done is 1 for exactly one cycle, which is the first cycle in which shutter is 1 again. It is 0 at all other times.
- R8: chip_rst is 1 during all PRE_CYC closed cycles before the strobe if rst_en was 1 at acceptance. It is 0 at every other time.
- R9: busy is 1 in the same cycle that any bit of buf_afull is 1.
- R10: busy is 1 whenever halt is 1, and it is 0 when halt is 0 and every buf_afull bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_req | input | 1 | Request to run a resynchronisation sequence |
| rst_en | input | 1 | Issue a chip reset during the closed window |
| gap_cycles | input | CNT_W | Requested gap after the strobe, in cycles |
| buf_afull | input | N_BUF | Almost-full flags of the output buffers |
| halt | input | 1 | Software halt bit |
| shutter | output | 1 | Shutter to chips, 1 = open |
| t0_sync | output | 1 | Time-stamp synchronisation strobe |
| chip_rst | output | 1 | Optional internal chip reset pulse |
| busy | output | 1 | Merged busy toward the trigger unit |
| done | output | 1 | One-cycle pulse when the shutter reopens |

## Verification
The bench targets gap values below, at and just above the minimum, including zero. A design that skipped the clamp would reopen the shutter too early, and an off-by-one counter would move the reopening edge by one cycle. During every sequence the bench also raises extra requests and changes the gap and reset-enable inputs at random. A design that restarted or resampled on those would show a longer or shorter closed window, a missing or stray chip reset, or a second sequence after done. Busy is driven with random flag and halt patterns, so a dropped flag bit or a latched term would show up as a wrong busy value in that same cycle.

// File: rtl/sync_seq.sv
module sync_seq #(
  parameter int N_BUF     = 4,
  parameter int CNT_W     = 16,
  parameter int PRE_CYC   = 2,
  parameter int PULSE_CYC = 1,
  parameter int MIN_GAP   = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] gap_cycles,
  input  logic [N_BUF-1:0] buf_afull,
  input  logic             halt,
  output logic             shutter,
  output logic             t0_sync,
  output logic             chip_rst,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_CLOSE, S_PULSE, S_GAP} st_t;

  localparam logic [CNT_W-1:0] MinGap   = CNT_W'(MIN_GAP);
  localparam logic [CNT_W-1:0] PreLoad  = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] PulsLoad = CNT_W'(PULSE_CYC - 1);

  st_t              st;
  logic [CNT_W-1:0] cnt, gap_q;
  logic             rst_q, done_q;

  wire [CNT_W-1:0] gap_eff = (gap_cycles < MinGap) ? MinGap : gap_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      gap_q  <= '0;
      rst_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE:
          if (sync_req) begin
            st    <= S_CLOSE;
            cnt   <= PreLoad;
            gap_q <= gap_eff;
            rst_q <= rst_en;
          end
        S_CLOSE:
          if (cnt == '0) begin
            st  <= S_PULSE;
            cnt <= PulsLoad;
          end else cnt <= cnt - 1'b1;
        S_PULSE:
          if (cnt == '0) begin
            st  <= S_GAP;
            cnt <= gap_q - 1'b1;
          end else cnt <= cnt - 1'b1;
        S_GAP:
          if (cnt == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign shutter  = (st == S_IDLE);
  assign t0_sync  = (st == S_PULSE);
  assign chip_rst = (st == S_CLOSE) && rst_q;
  assign done     = done_q;
  assign busy     = (|buf_afull) | halt;
endmodule

// File: rtl/sync_seq_chk.sv
module sync_seq_chk #(
  parameter int N_BUF   = 4,
  parameter int MIN_GAP = 65
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_BUF-1:0] buf_afull,
  input logic             halt,
  input logic             shutter,
  input logic             t0_sync,
  input logic             chip_rst,
  input logic             busy,
  input logic             done
);
  int unsigned gcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) gcnt <= 0;
    else if (t0_sync) gcnt <= 0;
    else if (!shutter && gcnt < 32'hFFFF_FFFF) gcnt <= gcnt + 1;
  end

  p_strobe_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t0_sync |-> !shutter);
  p_margin_before_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t0_sync) |-> $past(!shutter));
  p_margin_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t0_sync) |-> !shutter);
  p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutter) |-> (gcnt >= MIN_GAP));
  p_done_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (shutter && $past(!shutter)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_rst_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> (!shutter && !t0_sync));
  p_flag_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_afull != '0) |-> busy);
  p_halt_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> busy);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && buf_afull == '0) |-> !busy);
endmodule

bind sync_seq sync_seq_chk #(.N_BUF(N_BUF), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_afull(buf_afull), .halt(halt),
  .shutter(shutter), .t0_sync(t0_sync), .chip_rst(chip_rst),
  .busy(busy), .done(done)
);

// File: tb/sync_seq_test.sv
module sync_seq_test;
  localparam int CLK_PERIOD = 25;
  localparam int N_BUF = 4, CNT_W = 16, PRE = 2, PUL = 1, MING = 65;

  logic clk = 0, rst_n = 0, sync_req = 0, rst_en = 0, halt = 0;
  logic [CNT_W-1:0] gap_cycles = '0;
  logic [N_BUF-1:0] buf_afull = '0;
  logic shutter, t0_sync, chip_rst, busy, done;
  int checks = 0, fails = 0;

  sync_seq #(.N_BUF(N_BUF), .CNT_W(CNT_W), .PRE_CYC(PRE), .PULSE_CYC(PUL),
             .MIN_GAP(MING)) uut (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .rst_en(rst_en),
    .gap_cycles(gap_cycles), .buf_afull(buf_afull), .halt(halt),
    .shutter(shutter), .t0_sync(t0_sync), .chip_rst(chip_rst),
    .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff_gap(int g);
    return (g < MING) ? MING : g;
  endfunction
  function automatic logic exp_shut(int j, int g);
    return j >= PRE + PUL + eff_gap(g);
  endfunction
  function automatic logic exp_t0(int j);
    return (j >= PRE) && (j < PRE + PUL);
  endfunction
  function automatic logic exp_rst(int j, logic en);
    return en && (j < PRE);
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_seq(int g, logic en, logic noise);
    int total = PRE + PUL + eff_gap(g);
    @(negedge clk);
    gap_cycles = CNT_W'(g); rst_en = en; sync_req = 1;
    for (int j = 0; j <= total + 3; j++) begin
      @(negedge clk);
      sync_req = 0;
      chk(shutter, exp_shut(j, g), "R2/R4/R6 shutter");
      chk(t0_sync, exp_t0(j), "R3 t0_sync");
      chk(chip_rst, exp_rst(j, en), "R8/R5 chip_rst");
      chk(done, (j == total), "R7 done");
      if (noise && j < total - 1) begin
        sync_req   = 1'($urandom);
        gap_cycles = CNT_W'($urandom % 300);
        rst_en     = 1'($urandom);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(shutter, 1'b1, "R1 shutter");
    chk(t0_sync, 1'b0, "R1 t0_sync");
    chk(chip_rst, 1'b0, "R1 chip_rst");
    chk(done, 1'b0, "R1 done");
    rst_n = 1;
    @(negedge clk);
    chk(shutter, 1'b1, "R1 shutter after release");
    run_seq(0, 1'b0, 1'b0);
    run_seq(64, 1'b1, 1'b0);
    run_seq(65, 1'b0, 1'b1);
    run_seq(66, 1'b1, 1'b1);
    run_seq(1, 1'b1, 1'b1);
    for (int k = 0; k < 25; k++)
      run_seq(int'($urandom % 260), 1'($urandom), 1'b1);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      buf_afull = N_BUF'($urandom);
      halt = ($urandom % 4) == 0;
      if (k == 0) begin buf_afull = '0; halt = 0; end
      if (k == 1) begin buf_afull = 4'b1000; halt = 0; end
      if (k == 2) begin buf_afull = '0; halt = 1; end
      #1;
      if (buf_afull != '0) chk(busy, 1'b1, "R9 busy on flag");
      else chk(busy, halt, "R10 busy from halt");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule